// File: doc/BRIEF.md
# Vector Multiply-Accumulate Processing Chain

This block is a linear chain of processing elements that computes many dot products at once. A document vector is streamed into the left end of the chain one beat at a time. Each beat carries a bus of `2*NPE` signed 16-bit words, and that bus moves one element to the right every cycle. Every element drives two multiply-accumulate lanes. Each lane multiplies the bus word it selects by the query word held in its own private store at the current position in the vector, and adds the product into a 32-bit running sum. The start-of-vector and end-of-vector strobes travel with the data. A start strobe restarts the sums. An end strobe freezes each sum into a result.

Results travel right to left over a single shared link and leave at the first element, one per cycle, each tagged with its lane number. A mode bit is carried along with every beat and selects how lanes pick their operand. In one setting each lane takes its own word of the bus. In the other, every lane takes word 0, so each lane scores the same streamed value against its own stored query. Query words are loaded beforehand through an addressed write port. The outer control must keep the end strobes of consecutive vectors at least `2*NPE` cycles apart. When a vector is shorter than the chain, that rule is met by adding idle beats.

Top module: `mac_chain`

## Requirements
- R1: After reset, `res_valid` stays low until a vector's end beat has been accepted.
- R2: A write with `wr_en` high stores `wr_data` for lane `wr_lane` at position `wr_addr`. Every later vector uses the stored value as that lane's query operand at that beat position.
- R3: Each lane multiplies two signed 16-bit operands and adds the product into a 32-bit sum that wraps modulo 2^32.
- R4: A valid beat with `in_sos` high restarts position counting at 0 and discards the previous sum. A beat with both `in_sos` and `in_eos` high forms a one-beat vector.
- R5: With `mode`=0 on a beat, lane j uses bus word j, which is `in_data[16*j +: 16]`.
- R6: With `mode`=1 on a beat, every lane uses bus word 0, and the other bus words have no effect on any result.
- R7: For an end beat sampled at clock edge E, the result of lane j is on the output after edge E+1+j. Results appear one per cycle in ascending lane order, with `res_lane`=j.
- R8: The next end beat may follow at edge E+2*NPE or later. This allows back-to-back vectors of length 2*NPE or more, and no result is lost or corrupted.
- R9: Beats with `in_valid` low are ignored, whatever their strobes or data. They neither add to a sum nor advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | Operand select for the beat: 0 = lane's own word, 1 = word 0 to all lanes |
| in_valid | input | 1 | Beat is valid |
| in_sos | input | 1 | First beat of a vector |
| in_eos | input | 1 | Last beat of a vector |
| in_data | input | 2*NPE*DW | Streamed document words, word j at bits 16*j upward |
| wr_en | input | 1 | Query store write enable |
| wr_lane | input | clog2(2*NPE) | Lane whose store is written |
| wr_addr | input | clog2(DEPTH) | Position within the vector |
| wr_data | input | DW | Query word |
| res_valid | output | 1 | Result present |
| res_lane | output | clog2(2*NPE) | Lane that produced the result |
| res_data | output | 2*DW | Dot product, two's complement |

## Verification
The bench builds the chain with three elements (six lanes) and a store depth of eight. Because the lane count is not a power of two, the lane tag cannot roll over cleanly, and the element count is odd. Vector lengths from one to eight fall on both sides of the chain length. Short vectors therefore need inserted idle beats, while vectors of six or more beats can run back to back, with a new vector accumulating while the previous results drain. Full-scale negative operands push the sums through wraparound, and the mode toggles between vectors.

// File: rtl/mac_chain.sv
module mac_chain #(
  parameter int NPE   = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode,
  input  logic                    in_valid,
  input  logic                    in_sos,
  input  logic                    in_eos,
  input  logic [2*NPE*DW-1:0]     in_data,
  input  logic                    wr_en,
  input  logic [$clog2(2*NPE)-1:0] wr_lane,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic                    res_valid,
  output logic [$clog2(2*NPE)-1:0] res_lane,
  output logic [2*DW-1:0]         res_data
);
  localparam int L    = 2 * NPE;
  localparam int ACCW = 2 * DW;
  localparam int LW   = $clog2(L);
  localparam int PW   = $clog2(DEPTH);

  logic [DW-1:0] qmem [L][DEPTH];

  always_ff @(posedge clk)
    if (wr_en) qmem[wr_lane][wr_addr] <= wr_data;

  logic [PW-1:0] pos_cnt;
  logic [PW-1:0] in_pos;
  assign in_pos = in_sos ? '0 : pos_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pos_cnt <= '0;
    else if (in_valid) pos_cnt <= in_pos + PW'(1);

  logic              s_vld  [NPE];
  logic              s_sos  [NPE];
  logic              s_eos  [NPE];
  logic              s_mode [NPE];
  logic [PW-1:0]     s_pos  [NPE];
  logic [L*DW-1:0]   s_dat  [NPE];
  logic              o_v    [NPE];
  logic [LW-1:0]     o_l    [NPE];
  logic [ACCW-1:0]   o_d    [NPE];
  logic              h_v    [NPE];
  logic [ACCW-1:0]   h_d    [NPE];
  logic signed [ACCW-1:0] acc    [L];
  logic signed [ACCW-1:0] acc_nx [L];

  for (genvar e = 0; e < NPE; e++) begin : g_pe
    logic            pv, ps, pq, pm;
    logic [PW-1:0]   pp;
    logic [L*DW-1:0] pd;
    logic            fv;
    logic [LW-1:0]   fl;
    logic [ACCW-1:0] fd;
    logic            own;

    if (e == 0) begin : g_src
      assign pv = in_valid;
      assign ps = in_sos;
      assign pq = in_eos;
      assign pm = mode;
      assign pp = in_pos;
      assign pd = in_data;
    end else begin : g_src
      assign pv = s_vld[e-1];
      assign ps = s_sos[e-1];
      assign pq = s_eos[e-1];
      assign pm = s_mode[e-1];
      assign pp = s_pos[e-1];
      assign pd = s_dat[e-1];
    end

    if (e == NPE - 1) begin : g_fwd
      assign fv = 1'b0;
      assign fl = '0;
      assign fd = '0;
    end else begin : g_fwd
      assign fv = o_v[e+1];
      assign fl = o_l[e+1];
      assign fd = o_d[e+1];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s_vld[e]  <= 1'b0;
        s_sos[e]  <= 1'b0;
        s_eos[e]  <= 1'b0;
        s_mode[e] <= 1'b0;
        s_pos[e]  <= '0;
        s_dat[e]  <= '0;
      end else begin
        s_vld[e]  <= pv;
        s_sos[e]  <= ps;
        s_eos[e]  <= pq;
        s_mode[e] <= pm;
        s_pos[e]  <= pp;
        s_dat[e]  <= pd;
      end

    for (genvar k = 0; k < 2; k++) begin : g_lane
      localparam int LN = 2 * e + k;
      logic [LW-1:0]          sel;
      logic signed [DW-1:0]   opa, opb;
      logic signed [ACCW-1:0] prod;

      assign sel  = s_mode[e] ? '0 : LW'(LN);
      assign opa  = s_dat[e][sel*DW +: DW];
      assign opb  = qmem[LN][s_pos[e]];
      assign prod = opa * opb;
      assign acc_nx[LN] = (s_sos[e] ? '0 : acc[LN]) + prod;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        acc[LN] <= '0;
        else if (s_vld[e]) acc[LN] <= acc_nx[LN];

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_vld[e] |=> $stable(acc[LN])) else $error("idle beat changed sum"); // R9
    end

    assign own = s_vld[e] && s_eos[e];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        o_v[e] <= 1'b0;
        o_l[e] <= '0;
        o_d[e] <= '0;
        h_v[e] <= 1'b0;
        h_d[e] <= '0;
      end else if (own) begin
        o_v[e] <= 1'b1;
        o_l[e] <= LW'(2 * e);
        o_d[e] <= acc_nx[2*e];
        h_v[e] <= 1'b1;
        h_d[e] <= acc_nx[2*e+1];
      end else if (h_v[e]) begin
        o_v[e] <= 1'b1;
        o_l[e] <= LW'(2 * e + 1);
        o_d[e] <= h_d[e];
        h_v[e] <= 1'b0;
      end else begin
        o_v[e] <= fv;
        o_l[e] <= fl;
        o_d[e] <= fd;
      end

    AST_LINK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (own || h_v[e]) |-> !fv) else $error("result link collision"); // R8
  end

  assign res_valid = o_v[0];
  assign res_lane  = o_l[0];
  assign res_data  = o_d[0];

  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> res_lane == '0) else $error("burst not led by lane 0"); // R7

  AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_lane != LW'(L - 1)) |=> (res_valid && res_lane == $past(res_lane) + LW'(1)))
    else $error("lane order broken"); // R7
endmodule

// File: tb/mac_chain_tb.sv
`timescale 1ns/1ps
module mac_chain_tb;
  localparam int NPE = 3, DW = 16, DEPTH = 8;
  localparam int L = 2 * NPE, LW = $clog2(L), PW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, in_valid = 1'b0, in_sos = 1'b0, in_eos = 1'b0;
  logic [L*DW-1:0] in_data = '0;
  logic wr_en = 1'b0;
  logic [LW-1:0] wr_lane = '0;
  logic [PW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic res_valid;
  logic [LW-1:0] res_lane;
  logic [2*DW-1:0] res_data;

  always #4 clk = ~clk;

  mac_chain #(.NPE(NPE), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_sos(in_sos),
    .in_eos(in_eos), .in_data(in_data), .wr_en(wr_en), .wr_lane(wr_lane),
    .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid),
    .res_lane(res_lane), .res_data(res_data));

  int errors = 0, checks = 0, cyc = 0, last_eos = -100;
  bit done = 1'b0;
  int q [L][DEPTH];
  int dw [DEPTH][L];
  int exp_cyc [$];
  int exp_lane [$];
  logic [31:0] exp_val [$];
  string exp_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
      chk(res_valid, exp_tag[0], "result missing in slot (R7)", res_valid, 1);
      chk(res_lane == LW'(exp_lane[0]), exp_tag[0], "lane tag (R7)", res_lane, exp_lane[0]);
      chk(res_data == exp_val[0], exp_tag[0], "dot product", res_data, exp_val[0]);
      void'(exp_cyc.pop_front()); void'(exp_lane.pop_front());
      void'(exp_val.pop_front()); void'(exp_tag.pop_front());
    end else if (res_valid) begin
      chk(1'b0, "R7", "unexpected result", res_lane, 0);
    end
  end

  task automatic wr(int ln, int a, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_lane = LW'(ln); wr_addr = PW'(a); wr_data = DW'(v);
    q[ln][a] = int'($signed(DW'(v)));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_beat(bit junk);
    @(negedge clk);
    in_valid = 1'b0;
    mode = 1'(($urandom));
    in_sos = junk; in_eos = junk;
    for (int w = 0; w < L; w++) in_data[w*DW +: DW] = DW'($urandom);
  endtask

  task automatic vec(bit m, int len, bit bubbles, bit full_neg, string tag_in);
    string tag;
    bit had_bubble = 1'b0;
    for (int b = 0; b < len; b++) begin
      if (bubbles && ($urandom % 3 == 0)) begin idle_beat(1'b1); had_bubble = 1'b1; end
      if (b == len - 1) while (cyc + 1 < last_eos + L) idle_beat(1'b0);
      @(negedge clk);
      in_valid = 1'b1; in_sos = (b == 0); in_eos = (b == len - 1); mode = m;
      for (int w = 0; w < L; w++) begin
        dw[b][w] = full_neg ? -32768 : int'($signed(DW'($urandom)));
        in_data[w*DW +: DW] = DW'(dw[b][w]);
      end
      if (b == len - 1) begin
        tag = tag_in;
        if (tag == "") tag = had_bubble ? "R9" : (cyc + 1 == last_eos + L) ? "R8" : (m ? "R6" : "R5");
        for (int j = 0; j < L; j++) begin
          int s = 0;
          for (int k = 0; k < len; k++) s += q[j][k] * (m ? dw[k][0] : dw[k][j]);
          exp_cyc.push_back(cyc + 2 + j); exp_lane.push_back(j);
          exp_val.push_back(32'(s)); exp_tag.push_back(tag);
        end
        last_eos = cyc + 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sos = 1'b0; in_eos = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);
    end
    for (int ln = 0; ln < L; ln++)
      for (int a = 0; a < DEPTH; a++) wr(ln, a, int'($urandom));
    vec(1'b0, 1, 1'b0, 1'b0, "R4");
    vec(1'b0, 1, 1'b0, 1'b0, "R4");
    vec(1'b1, 3, 1'b0, 1'b0, "R6");
    vec(1'b0, 4, 1'b0, 1'b0, "R5");
    for (int a = 0; a < 3; a++) begin wr(0, a, -32768); wr(3, a, 32767); end
    vec(1'b0, 3, 1'b0, 1'b1, "R3");
    vec(1'b1, 3, 1'b0, 1'b1, "R3");
    wr(2, 0, 5); wr(5, 1, -7);
    vec(1'b0, 2, 1'b0, 1'b0, "R2");
    vec(1'b1, 2, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) vec(1'(i), 7, 1'b0, 1'b0, "");
    vec(1'b0, 8, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 40; i++)
      vec(1'($urandom), 1 + int'($urandom % DEPTH), ($urandom % 4) == 0, 1'b0, "");
    repeat (3 * L) @(negedge clk);
    chk(exp_cyc.size() == 0, "R7", "results outstanding", exp_cyc.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule